// File: doc/BRIEF.md
# I2C Register-File Target

This block is an I2C target that gives a host controller access to a bank of 8-bit registers. It answers a single fixed 7-bit device address. A write transaction names a register with a pointer byte and then carries one data byte. A read transaction sets the pointer with a write, then issues a repeated START (or a STOP followed by a new START), addresses the device for reading and clocks out one byte. The block samples SCL and SDA with its own system clock, after a synchronizer. It pulls SDA low through an output-enable and a constant-zero data output, which model an open-drain pad.

The register space has four kinds of location. Index 0 is a fixed identity value and index 1 is a fixed revision value. Both are read-only, and writing either one raises a one-cycle command-abort strobe. The next block of locations is read-only status, taken live from an input vector. One status bit acts as a busy flag and blocks stores while it is set. Every location above the status block is a read/write control register, and the contents of these registers drive a parallel output. Writes never advance the pointer.

Top module: `i2cr_slave`

## Requirements
- R1: The target acknowledges the address bytes C0h (write) and C1h (read), which is the 7-bit address 60h. Any other address byte gets no ACK, and every byte up to the next START is then ignored and not acknowledged, including a later C0h.
- R2: The sequence START, C0h, pointer, data, STOP stores the data in the read/write register at the pointer. The stored value then appears on `ctrl_q[8*p+7:8*p]` and is returned by a read of that pointer.
- R3: In a write transaction only the first byte after the pointer is stored. Later data bytes are acknowledged, change no register and do not advance the pointer.
- R4: A read (C0h, pointer, repeated START or STOP+START, C1h, byte) returns the value at the pointer, most significant bit first. If the host ACKs, the same register is sent again. After a NACK the target releases SDA.
- R5: Register 00h reads 1Bh and register 01h reads 00h. A write to either of them is acknowledged, leaves both values unchanged and produces exactly one `abort_o` pulse of one clock cycle. This happens whether or not the busy flag is set.
- R6: Registers 02h to 07h return the status input, with register 02h+k returning `stat_i[8k+7:8k]`. Writes to these registers are acknowledged and change nothing.
- R7: While `stat_i[7]` (bit 7 of register 02h, the busy flag) is 1, writes to the read/write registers are acknowledged but not stored.
- R8: A START or STOP in the middle of a byte abandons the transfer without storing anything. After a START the next byte is treated as an address byte.
- R9: After reset, `sda_oe` and `abort_o` are 0 and every read/write register holds 00h.
- R10: The target changes `sda_oe` only while SCL is low. A STOP leaves SDA released.
- R11: A pointer at or above the register count reads as 00h. A write to such a pointer changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| stat_i | input | STAT_COUNT*8 | Live status bytes for registers 02h and up; bit 7 is the busy flag |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_o | output | 1 | Value driven when enabled, always 0 |
| abort_o | output | 1 | One-cycle command-abort strobe |
| ctrl_q | output | NUM_REGS*8 | Stored register contents, 8 bits per index; read-only lanes are 0 |

## Verification
The properties assume a well-behaved host. The host changes SDA only while SCL is low, except when it forms a START or STOP. It never forms a START or STOP while the target holds SDA low. Every SCL phase lasts several system clocks longer than the synchronizer delay. The bench's bus tasks meet these assumptions by design: each SCL quarter period is five clocks and SDA changes in the middle of the low phase. Random traffic varies pointers, data, status bytes and the busy flag. Directed cases add wrong addresses, extra data bytes, partial bytes cut off by START or STOP, master-ACKed reads and out-of-range pointers.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
   localparam int PTR_W      = 8;
   localparam int ABORT_REGS = 2;

   typedef enum logic [2:0] {
      ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_IGN
   } eng_st_e;

   typedef enum logic [1:0] {
      K_ADDR, K_PTR, K_DATA
   } byte_kind_e;
endpackage

// File: rtl/i2cr_sync.sv
module i2cr_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
   logic scl_prev, sda_prev;

   generate
      if (SYNC_STAGES < 2) begin : g_bad
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff   <= '1;
         sda_ff   <= '1;
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_ff   <= {scl_ff[SYNC_STAGES-2:0], scl_i};
         sda_ff   <= {sda_ff[SYNC_STAGES-2:0], sda_i};
         scl_prev <= scl_ff[SYNC_STAGES-1];
         sda_prev <= sda_ff[SYNC_STAGES-1];
      end
   end

   assign scl_s     = scl_ff[SYNC_STAGES-1];
   assign sda_s     = sda_ff[SYNC_STAGES-1];
   assign scl_rise  = scl_s & ~scl_prev;
   assign scl_fall  = ~scl_s & scl_prev;
   assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
   assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2cr_engine.sv
module i2cr_engine
   import i2cr_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h60
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sda_s,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic [7:0]       rd_data,
   output logic [PTR_W-1:0] ptr_q,
   output logic             wr_en,
   output logic [7:0]       wr_data,
   output logic             sda_oe
);
   eng_st_e    st_q;
   byte_kind_e kind_q;
   logic [3:0] cnt_q;
   logic [7:0] sh_q;
   logic [7:0] tx_q;
   logic       rw_q;
   logic       first_q;
   logic       nack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         kind_q  <= K_ADDR;
         cnt_q   <= '0;
         sh_q    <= '0;
         tx_q    <= '0;
         rw_q    <= 1'b0;
         first_q <= 1'b0;
         nack_q  <= 1'b1;
         ptr_q   <= '0;
         wr_en   <= 1'b0;
         wr_data <= '0;
         sda_oe  <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (stop_det) begin
            st_q   <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (start_det) begin
            st_q    <= ST_RX;
            kind_q  <= K_ADDR;
            cnt_q   <= '0;
            first_q <= 1'b1;
            sda_oe  <= 1'b0;
         end else begin
            case (st_q)
               ST_RX: begin
                  if (scl_rise && cnt_q != 4'd8) begin
                     sh_q  <= {sh_q[6:0], sda_s};
                     cnt_q <= cnt_q + 4'd1;
                  end else if (scl_fall && cnt_q == 4'd8) begin
                     case (kind_q)
                        K_ADDR: begin
                           if (sh_q[7:1] == DEV_ADDR) begin
                              rw_q   <= sh_q[0];
                              sda_oe <= 1'b1;
                              st_q   <= ST_ACK;
                           end else begin
                              st_q <= ST_IGN;
                           end
                        end
                        K_PTR: begin
                           ptr_q  <= sh_q;
                           sda_oe <= 1'b1;
                           st_q   <= ST_ACK;
                        end
                        default: begin
                           if (first_q) begin
                              wr_en   <= 1'b1;
                              wr_data <= sh_q;
                              first_q <= 1'b0;
                           end
                           sda_oe <= 1'b1;
                           st_q   <= ST_ACK;
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     cnt_q <= '0;
                     if (kind_q == K_ADDR && rw_q) begin
                        tx_q   <= rd_data;
                        sda_oe <= ~rd_data[7];
                        st_q   <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        st_q   <= ST_RX;
                        kind_q <= (kind_q == K_ADDR) ? K_PTR : K_DATA;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (cnt_q == 4'd7) begin
                        sda_oe <= 1'b0;
                        st_q   <= ST_MACK;
                     end else begin
                        tx_q   <= {tx_q[6:0], 1'b0};
                        sda_oe <= ~tx_q[6];
                        cnt_q  <= cnt_q + 4'd1;
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     nack_q <= sda_s;
                  end else if (scl_fall) begin
                     if (!nack_q) begin
                        tx_q   <= rd_data;
                        sda_oe <= ~rd_data[7];
                        cnt_q  <= '0;
                        st_q   <= ST_TX;
                     end else begin
                        st_q <= ST_IGN;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2cr_regbank.sv
module i2cr_regbank
   import i2cr_pkg::*;
#(
   parameter int         NUM_REGS   = 32,
   parameter int         STAT_COUNT = 6,
   parameter logic [7:0] ID_VAL     = 8'h1B,
   parameter logic [7:0] REV_VAL    = 8'h00,
   parameter logic [7:0] OOR_VAL    = 8'h00
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [PTR_W-1:0]        wr_ptr,
   input  logic [7:0]              wr_data,
   input  logic                    busy,
   input  logic [PTR_W-1:0]        rd_ptr,
   input  logic [STAT_COUNT*8-1:0] stat_i,
   output logic [7:0]              rd_data,
   output logic                    abort_o,
   output logic [NUM_REGS*8-1:0]   ctrl_q
);
   localparam int STAT_END = ABORT_REGS + STAT_COUNT;
   localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   logic [7:0] lane [NUM_REGS];

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         if (i == 0) begin : g_id
            assign lane[i]          = ID_VAL;
            assign ctrl_q[i*8 +: 8] = '0;
         end else if (i < ABORT_REGS) begin : g_rev
            assign lane[i]          = REV_VAL;
            assign ctrl_q[i*8 +: 8] = '0;
         end else if (i < STAT_END) begin : g_stat
            assign lane[i]          = stat_i[(i-ABORT_REGS)*8 +: 8];
            assign ctrl_q[i*8 +: 8] = '0;
         end else begin : g_rw
            logic [7:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                                   q <= '0;
               else if (wr_en && !busy && int'(wr_ptr) == i) q <= wr_data;
            end
            assign lane[i]          = q;
            assign ctrl_q[i*8 +: 8] = q;
         end
      end
   endgenerate

   always_comb begin
      rd_data = OOR_VAL;
      if (int'(rd_ptr) < NUM_REGS) rd_data = lane[rd_ptr[IDX_W-1:0]];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) abort_o <= 1'b0;
      else        abort_o <= wr_en && (int'(wr_ptr) < ABORT_REGS);
   end
endmodule

// File: rtl/i2cr_slave.sv
module i2cr_slave
   import i2cr_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h60,
   parameter int         NUM_REGS    = 32,
   parameter int         STAT_COUNT  = 6,
   parameter int         BUSY_REG    = 2,
   parameter int         BUSY_BIT    = 7,
   parameter logic [7:0] ID_VAL      = 8'h1B,
   parameter logic [7:0] REV_VAL     = 8'h00,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    scl_i,
   input  logic                    sda_i,
   input  logic [STAT_COUNT*8-1:0] stat_i,
   output logic                    sda_oe,
   output logic                    sda_o,
   output logic                    abort_o,
   output logic [NUM_REGS*8-1:0]   ctrl_q
);
   localparam int RW_BASE  = ABORT_REGS + STAT_COUNT;
   localparam int BUSY_IDX = (BUSY_REG - ABORT_REGS) * 8 + BUSY_BIT;

   generate
      if (NUM_REGS > 256 || NUM_REGS <= RW_BASE) begin : g_bad_regs
         $error("NUM_REGS must exceed the read-only area and fit an 8-bit pointer");
      end
      if (BUSY_REG < ABORT_REGS || BUSY_REG >= RW_BASE || BUSY_BIT > 7) begin : g_bad_busy
         $error("busy flag must sit inside the status area");
      end
   endgenerate

   logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [PTR_W-1:0] ptr_q;
   logic             wr_en;
   logic [7:0]       wr_data, rd_data;
   logic             busy;

   assign busy  = stat_i[BUSY_IDX];
   assign sda_o = 1'b0;

   i2cr_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   i2cr_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
      .rd_data(rd_data), .ptr_q(ptr_q), .wr_en(wr_en), .wr_data(wr_data),
      .sda_oe(sda_oe)
   );

   i2cr_regbank #(
      .NUM_REGS(NUM_REGS), .STAT_COUNT(STAT_COUNT),
      .ID_VAL(ID_VAL), .REV_VAL(REV_VAL), .OOR_VAL(8'h00)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(ptr_q),
      .wr_data(wr_data), .busy(busy), .rd_ptr(ptr_q), .stat_i(stat_i),
      .rd_data(rd_data), .abort_o(abort_o), .ctrl_q(ctrl_q)
   );
endmodule

// File: rtl/i2cr_chk.sv
module i2cr_chk #(
   parameter int NUM_REGS = 32,
   parameter int RW_BASE  = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  scl_s,
   input logic                  stop_det,
   input logic                  sda_oe,
   input logic                  abort_o,
   input logic                  wr_en,
   input logic [7:0]            wr_ptr,
   input logic [7:0]            wr_data,
   input logic                  busy,
   input logic [NUM_REGS*8-1:0] ctrl_q
);
   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !busy && int'(wr_ptr) >= RW_BASE && int'(wr_ptr) < NUM_REGS
      |=> ctrl_q[int'($past(wr_ptr))*8 +: 8] == $past(wr_data));

   a_r6_ro_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (int'(wr_ptr) < RW_BASE || int'(wr_ptr) >= NUM_REGS) |=> $stable(ctrl_q));

   a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && busy |=> $stable(ctrl_q));

   a_r5_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |=> !abort_o);

   a_r5_abort_source: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> $past(wr_en) && ($past(wr_ptr) < 8'd2));

   a_r10_oe_hold_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
      scl_s && $past(scl_s) |-> $stable(sda_oe));

   a_r8_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);
endmodule

bind i2cr_slave i2cr_chk #(.NUM_REGS(NUM_REGS), .RW_BASE(RW_BASE)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
   .sda_oe(sda_oe), .abort_o(abort_o), .wr_en(wr_en), .wr_ptr(ptr_q),
   .wr_data(wr_data), .busy(busy), .ctrl_q(ctrl_q)
);

// File: tb/tb_i2cr_slave.sv
module tb_i2cr_slave;
   localparam int NREG = 32;
   localparam int NST  = 6;
   localparam int Q    = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            scl = 1'b1;
   logic            m_sda = 1'b1;
   logic [NST*8-1:0] stat_i = '0;
   logic            sda_oe, sda_o, abort_o;
   logic [NREG*8-1:0] ctrl_q;
   logic            sda_bus;

   int nvec = 0, nerr = 0;
   int abort_cnt = 0, abort_wide = 0, oe_viol = 0;
   logic prev_abort = 1'b0, prev_oe = 1'b0, prev_scl = 1'b1;
   logic [7:0] mem [NREG];
   bit done = 0;

   assign sda_bus = m_sda & ~sda_oe;

   always #2 clk = ~clk;

   i2cr_slave dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .stat_i(stat_i),
      .sda_oe(sda_oe), .sda_o(sda_o), .abort_o(abort_o), .ctrl_q(ctrl_q)
   );

   always @(posedge clk) begin
      if (rst_n) begin
         if (abort_o) abort_cnt++;
         if (abort_o && prev_abort) abort_wide++;
         if (sda_oe != prev_oe && scl && prev_scl) oe_viol++;
      end
      prev_abort <= abort_o;
      prev_oe    <= sda_oe;
      prev_scl   <= scl;
   end

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic qw();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b0; qw(); qw(); scl = 1'b0;
   endtask

   task automatic bus_rstart();
      qw(); m_sda = 1'b1; qw(); scl = 1'b1; qw(); m_sda = 1'b0; qw(); scl = 1'b0;
   endtask

   task automatic bus_stop();
      qw(); m_sda = 1'b0; qw(); scl = 1'b1; qw(); m_sda = 1'b1; qw(); qw();
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         qw(); m_sda = b[i]; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0;
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      send_bits(b, 8);
      qw(); m_sda = 1'b1; qw(); scl = 1'b1; qw(); ack = sda_bus; qw(); scl = 1'b0;
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         qw(); m_sda = 1'b1; qw(); scl = 1'b1; qw(); b[i] = sda_bus; qw(); scl = 1'b0;
      end
      qw(); m_sda = mack; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0;
   endtask

   task automatic wr_txn(input logic [7:0] p, input logic [7:0] d);
      logic a;
      bus_start();
      send_byte(8'hC0, a); check("R1 addr ack", {7'd0, a}, 8'd0);
      send_byte(p, a);     check("R2 ptr ack", {7'd0, a}, 8'd0);
      send_byte(d, a);     check("R2 data ack", {7'd0, a}, 8'd0);
      bus_stop();
   endtask

   task automatic rd_txn(input logic [7:0] p, input bit use_stop, output logic [7:0] d);
      logic a;
      bus_start();
      send_byte(8'hC0, a);
      send_byte(p, a);
      if (use_stop) begin bus_stop(); bus_start(); end
      else bus_rstart();
      send_byte(8'hC1, a); check("R1 read addr ack", {7'd0, a}, 8'd0);
      recv_byte(1'b1, d);
      bus_stop();
   endtask

   function automatic logic [7:0] exp_read(input int p);
      if (p == 0) return 8'h1B;
      if (p == 1) return 8'h00;
      if (p < 2 + NST) return stat_i[(p-2)*8 +: 8];
      if (p < NREG) return mem[p];
      return 8'h00;
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end

   initial begin
      logic [7:0] r, r2;
      logic a;
      logic [NREG*8-1:0] snap;
      int ab0;
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < NREG; i++) mem[i] = 8'h00;
      repeat (10) @(negedge clk);
      check("R9 oe reset", {7'd0, sda_oe}, 8'd0);
      check("R9 abort reset", {7'd0, abort_o}, 8'd0);
      check("R9 regs reset", {7'd0, |ctrl_q}, 8'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R5 identity and revision
      rd_txn(8'h00, 0, r); check("R5 id", r, 8'h1B);
      rd_txn(8'h01, 1, r); check("R5 rev", r, 8'h00);
      ab0 = abort_cnt;
      wr_txn(8'h00, 8'h55);
      check("R5 abort count reg0", 8'(abort_cnt - ab0), 8'd1);
      rd_txn(8'h00, 0, r); check("R5 id kept", r, 8'h1B);
      stat_i = 48'h0000_0000_0080;
      ab0 = abort_cnt;
      wr_txn(8'h01, 8'hAA);
      check("R5 abort while busy", 8'(abort_cnt - ab0), 8'd1);
      rd_txn(8'h01, 0, r); check("R5 rev kept", r, 8'h00);
      stat_i = '0;

      // R2 basic write / read, ctrl lane
      wr_txn(8'h08, 8'hA5); mem[8] = 8'hA5;
      check("R2 lane", ctrl_q[8*8 +: 8], 8'hA5);
      rd_txn(8'h08, 0, r); check("R2 readback", r, 8'hA5);

      // R3 extra data bytes
      bus_start();
      send_byte(8'hC0, a); send_byte(8'h0C, a);
      send_byte(8'h3C, a); check("R3 first ack", {7'd0, a}, 8'd0);
      send_byte(8'h77, a); check("R3 extra ack", {7'd0, a}, 8'd0);
      send_byte(8'h99, a); check("R3 extra ack2", {7'd0, a}, 8'd0);
      bus_stop(); mem[12] = 8'h3C;
      check("R3 first stored", ctrl_q[12*8 +: 8], 8'h3C);
      check("R3 next untouched", ctrl_q[13*8 +: 8], 8'h00);

      // R4 master ACK repeats same register
      wr_txn(8'h09, 8'hC3); mem[9] = 8'hC3;
      bus_start(); send_byte(8'hC0, a); send_byte(8'h09, a); bus_rstart();
      send_byte(8'hC1, a);
      recv_byte(1'b0, r); recv_byte(1'b1, r2); bus_stop();
      check("R4 first byte", r, 8'hC3);
      check("R4 repeat no increment", r2, 8'hC3);
      check("R10 released after nack", {7'd0, sda_oe}, 8'd0);

      // R1 wrong address
      bus_start();
      send_byte(8'hA4, a); check("R1 wrong addr nack", {7'd0, a}, 8'd1);
      send_byte(8'hC0, a); check("R1 ignored until start", {7'd0, a}, 8'd1);
      send_byte(8'h5A, a); bus_stop();
      check("R1 no write", ctrl_q[8*8 +: 8], 8'hA5);

      // R6 status read and ignored write
      stat_i = 48'h1122_3344_5566;
      for (int p = 2; p < 8; p++) begin
         rd_txn(8'(p), 0, r); check("R6 status read", r, exp_read(p));
      end
      snap = ctrl_q;
      wr_txn(8'h03, 8'hFF);
      rd_txn(8'h03, 0, r); check("R6 write ignored", r, 8'h55);
      check("R6 bank unchanged", {7'd0, ctrl_q == snap}, 8'd1);

      // R7 busy blocks
      stat_i = 48'h0000_0000_0080;
      wr_txn(8'h0A, 8'h42);
      check("R7 blocked", ctrl_q[10*8 +: 8], 8'h00);
      stat_i = '0;
      wr_txn(8'h0A, 8'h42); mem[10] = 8'h42;
      check("R7 after busy", ctrl_q[10*8 +: 8], 8'h42);

      // R8 mid-byte STOP and START
      bus_start(); send_byte(8'hC0, a); send_byte(8'h0B, a);
      send_bits(8'hF0, 4); bus_stop();
      check("R8 stop mid byte", ctrl_q[11*8 +: 8], 8'h00);
      bus_start(); send_byte(8'hC0, a); send_byte(8'h0B, a);
      send_bits(8'hF0, 3); bus_rstart();
      send_byte(8'hC0, a); check("R8 start restarts addr", {7'd0, a}, 8'd0);
      send_byte(8'h0E, a); send_byte(8'h6D, a); bus_stop(); mem[14] = 8'h6D;
      check("R8 partial not stored", ctrl_q[11*8 +: 8], 8'h00);
      check("R8 new txn stored", ctrl_q[14*8 +: 8], 8'h6D);

      // R11 out of range
      snap = ctrl_q;
      wr_txn(8'h40, 8'h77);
      check("R11 bank unchanged", {7'd0, ctrl_q == snap}, 8'd1);
      rd_txn(8'h40, 0, r); check("R11 read zero", r, 8'h00);

      // constrained random traffic
      for (int it = 0; it < 24; it++) begin
         int p, rp;
         logic [7:0] d;
         bit bz;
         logic [47:0] st;
         p  = 8 + $urandom_range(0, NREG - 9);
         d  = 8'($urandom);
         bz = ($urandom_range(0, 3) == 0);
         st = {16'($urandom), 32'($urandom)};
         st[7] = bz;
         stat_i = st;
         wr_txn(8'(p), d);
         if (!bz) mem[p] = d;
         check(bz ? "R7 random busy" : "R2 random write", ctrl_q[p*8 +: 8], mem[p]);
         rp = $urandom_range(0, NREG + 7);
         rd_txn(8'(rp), it[0], r);
         check("R4 random read", r, exp_read(rp));
      end

      check("R5 abort width", 8'(abort_wide), 8'd0);
      check("R10 oe changes only scl low", 8'(oe_viol), 8'd0);
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule